// File: doc/BRIEF.md
# Sleep and Clock Gating Controller

This block decides when a small microcontroller may power down and which clock enables stay asserted while it is down. The core raises a one-cycle sleep request. The controller grants the request only when no interrupt is pending or in service, and only after a guard interval of quiet cycles on the I/O bus. A request that arrives too early is held until the guard interval is satisfied. While the block is asleep, the core clock is always gated off. A configuration bit decides whether the peripheral clock is also gated. When the watchdog-side gate enable also allows it, the selected oscillator is switched off. The low-frequency oscillator is exempt and is never switched off.

A wake event, or any interrupt that becomes pending during sleep, returns the block to run mode. If the oscillator had been stopped, the core clock comes back only after a parameterised stabilisation interval. A two-bit status output reports the current mode. All clocks are modelled as enable signals.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: `core_clk_en` is 1 in run mode only. It is 0 in both sleep modes and during the wake-up stabilisation interval.
- R2: A sleep request, whether new or held, is dropped while any bit of `irq_pending` or `irq_active` is 1. The block stays in run mode and does not keep the request.
- R3: Sleep is entered only in a cycle with `io_access` = 0 that follows at least GUARD consecutive cycles with `io_access` = 0. A request that arrives earlier is held and is granted in the first cycle that meets the guard condition. The guard counter starts saturated at reset.
- R4: `periph_clk_en` is 1 in run mode. In sleep with the oscillator running, it equals the inverse of `pclk_halt` as sampled at sleep entry. It is 0 while the oscillator is stopped and during stabilisation.
- R5: The oscillator-stopped mode is entered only when `pclk_halt` and `osc_gate_en` are both 1 and the selected source is not the low-frequency one. In that mode all non-exempt bits of `osc_run` are 0.
- R6: When bit LF_IDX of `osc_sel` is 1, bit LF_IDX of `osc_run` is 1 in every mode. Selecting that source makes a sleep entry go to the clocks-running sleep mode.
- R7: In the clocks-running sleep mode, `wake_evt` = 1 or any `irq_pending` bit = 1 returns the block to run mode on the next cycle.
- R8: In the oscillator-stopped mode, a wake condition starts a stabilisation interval of exactly STAB cycles. During it `osc_run` equals `osc_sel` and the core clock is off. Run mode follows.
- R9: `status` encodes the mode as follows: 0 = run, 1 = sleep with the oscillator running, 2 = sleep with the oscillator stopped, 3 = stabilising after wake.
- R10: Outside the oscillator-stopped mode, `osc_run` equals `osc_sel` (one-hot).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_access | input | 1 | I/O bus IN or OUT in this cycle |
| sleep_req | input | 1 | One-cycle sleep request from the core |
| irq_pending | input | IRQ_W | Interrupt pending flags |
| irq_active | input | IRQ_W | Interrupt in-service flags |
| pclk_halt | input | 1 | 1: peripheral clock stops in sleep |
| osc_gate_en | input | 1 | Watchdog-side permission to stop the oscillator |
| osc_sel | input | NUM_OSC | One-hot oscillator select |
| wake_evt | input | 1 | External wake event |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | NUM_OSC | Run enable per oscillator |
| status | output | 2 | Current mode code |

## Verification
On every cycle, the embedded assertions check four rules. Sleep entry happens only with the guard satisfied and no interrupt flag set. The oscillator-stopped mode is entered only with both enables set and a non-exempt source. Wake from the clocks-running sleep mode takes exactly one cycle. Wake from the stopped mode always passes through stabilisation. The bench compares every output against a behavioural model on every clock, and its scenarios show what a property cannot. These include a request held across the guard interval and then granted, a refused request that is not remembered later, the exact length of stabilisation, and the peripheral enable following the configuration sampled at entry.

// File: rtl/slpctl_pkg.sv
package slpctl_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_NAP  = 2'd1,
        MODE_HALT = 2'd2,
        MODE_WAKE = 2'd3
    } mode_e;

endpackage

// File: rtl/slpctl_io_guard.sv
module slpctl_io_guard #(
    parameter int GUARD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic io_access,
    output logic guard_ok
);
    localparam int CW = $clog2(GUARD + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(GUARD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } guard_st_t;

    guard_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (io_access) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        guard_ok = (st_q.cnt == CNT_MAX) && !io_access;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GUARD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX); // R3

    AST_GUARD_IO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        io_access |=> !guard_ok); // R3

endmodule

// File: rtl/slpctl_fsm.sv
module slpctl_fsm
    import slpctl_pkg::*;
#(
    parameter int NUM_OSC = 4,
    parameter int LF_IDX  = 3,
    parameter int STAB    = 8,
    parameter int IRQ_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               guard_ok,
    input  logic [IRQ_W-1:0]   irq_pending,
    input  logic [IRQ_W-1:0]   irq_active,
    input  logic               pclk_halt,
    input  logic               osc_gate_en,
    input  logic [NUM_OSC-1:0] osc_sel,
    input  logic               wake_evt,
    output mode_e              mode,
    output logic               keep_periph
);
    localparam int SW = $clog2(STAB + 1);
    localparam logic [SW-1:0] WARM_LAST = SW'(STAB - 1);

    typedef struct packed {
        mode_e         mode;
        logic          hold;
        logic          keep;
        logic [SW-1:0] warm;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    logic irq_any;
    logic wake_any;
    logic want_sleep;
    logic stop_osc;

    always_comb begin
        irq_any    = (|irq_pending) || (|irq_active);
        wake_any   = wake_evt || (|irq_pending);
        want_sleep = sleep_req || st_q.hold;
        stop_osc   = pclk_halt && osc_gate_en && !osc_sel[LF_IDX];

        st_d = st_q;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (want_sleep) begin
                    if (irq_any) begin
                        st_d.hold = 1'b0;
                    end else if (guard_ok) begin
                        st_d.hold = 1'b0;
                        st_d.keep = !pclk_halt;
                        st_d.mode = stop_osc ? MODE_HALT : MODE_NAP;
                    end else begin
                        st_d.hold = 1'b1;
                    end
                end
            end
            MODE_NAP: begin
                st_d.hold = 1'b0;
                if (wake_any) begin
                    st_d.mode = MODE_RUN;
                end
            end
            MODE_HALT: begin
                st_d.hold = 1'b0;
                if (wake_any) begin
                    st_d.mode = MODE_WAKE;
                    st_d.warm = '0;
                end
            end
            MODE_WAKE: begin
                st_d.hold = 1'b0;
                if (st_q.warm == WARM_LAST) begin
                    st_d.mode = MODE_RUN;
                end else begin
                    st_d.warm = st_q.warm + 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase

        mode        = st_q.mode;
        keep_periph = st_q.keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RUN;
            st_q.hold <= 1'b0;
            st_q.keep <= 1'b1;
            st_q.warm <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_IRQ_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && irq_any) |=> (st_q.mode == MODE_RUN && !st_q.hold)); // R2

    AST_HALT_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && st_d.mode == MODE_HALT) |-> (pclk_halt && osc_gate_en)); // R5

    AST_LF_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RUN && osc_sel[LF_IDX]) |=> (st_q.mode != MODE_HALT)); // R6

    AST_NAP_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_NAP && wake_any) |=> (st_q.mode == MODE_RUN)); // R7

    AST_HALT_WAKES_VIA_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_HALT && wake_any) |=> (st_q.mode == MODE_WAKE && st_q.warm == '0)); // R8

    AST_WARM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.warm <= WARM_LAST); // R8

endmodule

// File: rtl/slpctl_clk_out.sv
module slpctl_clk_out
    import slpctl_pkg::*;
#(
    parameter int NUM_OSC = 4,
    parameter int LF_IDX  = 3
) (
    input  mode_e              mode,
    input  logic               keep_periph,
    input  logic [NUM_OSC-1:0] osc_sel,
    output logic               core_clk_en,
    output logic               periph_clk_en,
    output logic [NUM_OSC-1:0] osc_run,
    output logic [1:0]         status
);
    logic halted;

    always_comb begin
        halted        = (mode == MODE_HALT);
        core_clk_en   = (mode == MODE_RUN);
        periph_clk_en = (mode == MODE_RUN) || ((mode == MODE_NAP) && keep_periph);
        status        = mode;
    end

    for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
        if (i == LF_IDX) begin : g_exempt
            always_comb osc_run[i] = osc_sel[i];
        end else begin : g_gated
            always_comb osc_run[i] = osc_sel[i] && !halted;
        end
    end

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import slpctl_pkg::*;
#(
    parameter int NUM_OSC = 4,
    parameter int LF_IDX  = 3,
    parameter int GUARD   = 3,
    parameter int STAB    = 8,
    parameter int IRQ_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_access,
    input  logic               sleep_req,
    input  logic [IRQ_W-1:0]   irq_pending,
    input  logic [IRQ_W-1:0]   irq_active,
    input  logic               pclk_halt,
    input  logic               osc_gate_en,
    input  logic [NUM_OSC-1:0] osc_sel,
    input  logic               wake_evt,
    output logic               core_clk_en,
    output logic               periph_clk_en,
    output logic [NUM_OSC-1:0] osc_run,
    output logic [1:0]         status
);
    logic  guard_ok;
    mode_e mode;
    logic  keep_periph;

    slpctl_io_guard #(.GUARD(GUARD)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_access (io_access),
        .guard_ok  (guard_ok)
    );

    slpctl_fsm #(
        .NUM_OSC (NUM_OSC),
        .LF_IDX  (LF_IDX),
        .STAB    (STAB),
        .IRQ_W   (IRQ_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .guard_ok    (guard_ok),
        .irq_pending (irq_pending),
        .irq_active  (irq_active),
        .pclk_halt   (pclk_halt),
        .osc_gate_en (osc_gate_en),
        .osc_sel     (osc_sel),
        .wake_evt    (wake_evt),
        .mode        (mode),
        .keep_periph (keep_periph)
    );

    slpctl_clk_out #(
        .NUM_OSC (NUM_OSC),
        .LF_IDX  (LF_IDX)
    ) u_out (
        .mode          (mode),
        .keep_periph   (keep_periph),
        .osc_sel       (osc_sel),
        .core_clk_en   (core_clk_en),
        .periph_clk_en (periph_clk_en),
        .osc_run       (osc_run),
        .status        (status)
    );

    AST_ENTRY_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd0 && !guard_ok) |=> (status == 2'd0)); // R3

    AST_CORE_OFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd0) |-> !core_clk_en); // R1

    AST_LF_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        osc_sel[LF_IDX] |-> osc_run[LF_IDX]); // R6

endmodule

// File: tb/sleep_clk_ctrl_test.sv
module sleep_clk_ctrl_test;
    localparam int NUM_OSC = 4;
    localparam int LF_IDX  = 3;
    localparam int GUARD   = 3;
    localparam int STAB    = 8;
    localparam int IRQ_W   = 4;
    localparam logic [NUM_OSC-1:0] LF_MASK = NUM_OSC'(1) << LF_IDX;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               io_access = 1'b0;
    logic               sleep_req = 1'b0;
    logic [IRQ_W-1:0]   irq_pending = '0;
    logic [IRQ_W-1:0]   irq_active = '0;
    logic               pclk_halt = 1'b0;
    logic               osc_gate_en = 1'b0;
    logic [NUM_OSC-1:0] osc_sel = 4'b0001;
    logic               wake_evt = 1'b0;
    logic               core_clk_en;
    logic               periph_clk_en;
    logic [NUM_OSC-1:0] osc_run;
    logic [1:0]         status;

    int vectors = 0;
    int errors  = 0;

    int m_mode = 0;
    int m_gap  = GUARD;
    bit m_hold = 0;
    bit m_keep = 1;
    int m_warm = 0;

    always #2.5 clk = ~clk;

    sleep_clk_ctrl #(
        .NUM_OSC(NUM_OSC), .LF_IDX(LF_IDX), .GUARD(GUARD), .STAB(STAB), .IRQ_W(IRQ_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .io_access(io_access), .sleep_req(sleep_req),
        .irq_pending(irq_pending), .irq_active(irq_active), .pclk_halt(pclk_halt),
        .osc_gate_en(osc_gate_en), .osc_sel(osc_sel), .wake_evt(wake_evt),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .osc_run(osc_run), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: advances once per clock edge with the inputs held in that cycle
    task automatic model_step();
        bit irq;
        bit ready;
        if (!rst_n) begin
            m_mode = 0; m_gap = GUARD; m_hold = 0; m_keep = 1; m_warm = 0;
            return;
        end
        irq   = (irq_pending != 0) || (irq_active != 0);
        ready = (m_gap >= GUARD) && !io_access;
        case (m_mode)
            0: if (sleep_req || m_hold) begin
                   if (irq) m_hold = 0;
                   else if (ready) begin
                       m_hold = 0;
                       m_keep = !pclk_halt;
                       m_mode = (pclk_halt && osc_gate_en && !osc_sel[LF_IDX]) ? 2 : 1;
                   end else m_hold = 1;
               end
            1: if (wake_evt || irq_pending != 0) m_mode = 0;
            2: if (wake_evt || irq_pending != 0) begin m_mode = 3; m_warm = 0; end
            default: if (m_warm == STAB - 1) m_mode = 0; else m_warm++;
        endcase
        if (io_access) m_gap = 0;
        else if (m_gap < GUARD) m_gap++;
    endtask

    task automatic compare();
        int e_per;
        logic [NUM_OSC-1:0] e_osc;
        e_per = (m_mode == 0) ? 1 : (m_mode == 1) ? int'(m_keep) : 0;
        e_osc = (m_mode == 2) ? (osc_sel & LF_MASK) : osc_sel;
        chk(core_clk_en == (m_mode == 0), "R1 core_clk_en", core_clk_en, m_mode == 0);
        chk(periph_clk_en == e_per[0], "R4 periph_clk_en", periph_clk_en, e_per);
        chk(osc_run == e_osc, "R5 R6 R10 osc_run", osc_run, e_osc);
        chk(status == m_mode[1:0], "R9 status", status, m_mode);
    endtask

    task automatic tick();
        @(negedge clk);
        model_step();
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        tick();
        // reset state
        chk(status == 2'd0 && core_clk_en && periph_clk_en, "R9 reset run", status, 0);

        // R3: request right after I/O is held, then granted once the guard is met
        io_access = 1'b1; tick();
        io_access = 1'b0; sleep_req = 1'b1; tick();
        sleep_req = 1'b0;
        idle(2);
        chk(status == 2'd0, "R3 held during guard", status, 0);
        tick();
        chk(status == 2'd1, "R3 granted after guard", status, 1);
        chk(periph_clk_en == 1'b1, "R4 periph kept", periph_clk_en, 1);

        // R7: wake from clocks-running sleep in one cycle
        wake_evt = 1'b1; tick(); wake_evt = 1'b0;
        chk(status == 2'd0 && core_clk_en, "R7 nap wake", status, 0);

        // R2: refused while an interrupt is active, and not remembered
        idle(4);
        irq_active = 4'b0010; sleep_req = 1'b1; tick();
        sleep_req = 1'b0; tick();
        chk(status == 2'd0, "R2 refused", status, 0);
        irq_active = '0; idle(3);
        chk(status == 2'd0, "R2 not held", status, 0);

        // R5/R8: stop oscillator, then stabilise for STAB cycles
        pclk_halt = 1'b1; osc_gate_en = 1'b1; osc_sel = 4'b0001;
        sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        chk(status == 2'd2 && osc_run == '0, "R5 oscillator stopped", osc_run, 0);
        irq_pending = 4'b0100; tick(); irq_pending = '0;
        chk(status == 2'd3 && !core_clk_en && osc_run == 4'b0001, "R8 warm entry", status, 3);
        idle(STAB - 1);
        chk(status == 2'd3, "R8 still stabilising", status, 3);
        tick();
        chk(status == 2'd0 && core_clk_en, "R8 run after STAB", status, 0);

        // R6: low-frequency source is never stopped
        osc_sel = LF_MASK; idle(3);
        sleep_req = 1'b1; tick(); sleep_req = 1'b0;
        chk(status == 2'd1 && osc_run == LF_MASK, "R6 LF keeps running", osc_run, LF_MASK);
        chk(periph_clk_en == 1'b0, "R4 periph halted", periph_clk_en, 0);
        wake_evt = 1'b1; tick(); wake_evt = 1'b0;

        // Randomised traffic compared against the model on every clock
        for (int c = 0; c < 4000; c++) begin
            io_access   = ($urandom_range(0, 9) < 3);
            sleep_req   = ($urandom_range(0, 9) == 0);
            wake_evt    = ($urandom_range(0, 19) == 0);
            irq_pending = ($urandom_range(0, 29) == 0) ? IRQ_W'($urandom_range(1, 15)) : '0;
            irq_active  = ($urandom_range(0, 19) == 0) ? IRQ_W'($urandom_range(1, 15)) : '0;
            if ((c % 50) == 0) begin
                pclk_halt   = $urandom_range(0, 1) != 0;
                osc_gate_en = $urandom_range(0, 1) != 0;
                osc_sel     = NUM_OSC'(1) << $urandom_range(0, NUM_OSC - 1);
            end
            tick();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule